// File: doc/BRIEF.md
# NPSF Base Cell Address Generator

This block sequences the cell addresses for a neighborhood pattern sensitive fault test of an 8x8 bit-cell memory. The array is tiled into 3x3 blocks. A test-case number picks one position inside every block, and that position, repeated across all blocks, gives the set of base cells tested together. For each base cell the generator emits the base address and then the addresses of its four direct neighbors. A role flag tells the consumer whether each address is the base cell or a neighbor.

A test controller pulses `start` with a case number from 1 to 9. It takes each presented address by pulsing `advance`. Base positions and neighbor addresses that would fall outside the array are skipped on internal cycles with `addr_vld` low. `done` rises once the final address has been taken. Memory access, data patterns and result comparison belong to the consumer.

Top module: `npsf_addr_gen`

## Requirements
- R1: After reset `addr_vld` and `done` are low.
- R2: For case k (1..9) the base cells are every (row, col) with row = (k-1)/3 + 3i and col = (k-1)%3 + 3j, for i, j in 0..2, keeping only rows and columns below 8. Case 1 gives 00..66, case 2 gives 01..67, and case 9 gives only 22, 25, 52 and 55.
- R3: Base cells are visited row-major over the block grid (block row outer, block column inner). Each base is followed by its neighbors in the order north (row-1), south (row+1), west (col-1), east (col+1).
- R4: `addr` carries the row in bits [5:3] and the column in bits [2:0].
- R5: `is_base` is 1 while a base address is presented and 0 while a neighbor address is presented.
- R6: A neighbor address outside rows 0..7 or columns 0..7 is never presented. Every presented address lies inside the array.
- R7: While `addr_vld` is high and `advance` and `start` are low, `addr`, `is_base` and `addr_vld` hold on the next cycle.
- R8: When the last address is taken, `done` goes high and `addr_vld` goes low. Both stay that way until the next `start`.
- R9: A `start` with case 0 or a case above 9 raises `done` on the next cycle and presents no address.
- R10: A `start` during a run abandons it and restarts with the new case.
- R11: The cycle after a legal `start`, the first base cell is presented (`addr_vld` and `is_base` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run with `case_idx` |
| case_idx | input | 4 | Test case number, legal 1..9 |
| advance | input | 1 | Consumer takes the presented address |
| addr | output | 6 | Cell address {row, col} |
| addr_vld | output | 1 | `addr` is a cell to visit |
| is_base | output | 1 | 1 for a base cell, 0 for a neighbor |
| done | output | 1 | Run complete, or rejected case |

## Verification
The hardest situations to reach are the edge bases. Depending on the case, a base sitting on row 0, row 7, column 0 or column 7 loses one or two neighbors. In case 9, whole block positions drop out. The bench reaches these by running all nine cases to completion. It compares every presented address against a list built by its own coordinate loops, so any dropped or extra address shows up as a mismatch in sequence or count. A restart part-way through one case covers abandoning a run, and a deliberately stalled consumer covers the hold rule.

// File: rtl/npsf_pkg.sv
package npsf_pkg;
  typedef enum logic [2:0] {
    PH_BASE = 3'd0,
    PH_N    = 3'd1,
    PH_S    = 3'd2,
    PH_W    = 3'd3,
    PH_E    = 3'd4
  } nbr_ph_e;

  // Row displacement of the neighbor visited in a given phase.
  function automatic int ph_drow(logic [2:0] ph);
    case (ph)
      3'd1:    return -1;
      3'd2:    return 1;
      default: return 0;
    endcase
  endfunction

  // Column displacement of the neighbor visited in a given phase.
  function automatic int ph_dcol(logic [2:0] ph);
    case (ph)
      3'd3:    return -1;
      3'd4:    return 1;
      default: return 0;
    endcase
  endfunction

  // A case number is usable when it names one of the BLK*BLK block slots.
  function automatic logic case_legal(int k, int blk);
    return (k >= 1) && (k <= blk * blk);
  endfunction
endpackage

// File: rtl/npsf_case_dec.sv
module npsf_case_dec #(
  parameter int BLK    = 3,
  parameter int CASE_W = 4,
  parameter int OFF_W  = 2
) (
  input  logic [CASE_W-1:0] k,
  output logic              legal,
  output logic [OFF_W-1:0]  roff,
  output logic [OFF_W-1:0]  coff
);
  import npsf_pkg::*;

  int slot;

  always_comb begin
    legal = case_legal(int'(k), BLK);
    slot  = legal ? int'(k) - 1 : 0;
    roff  = OFF_W'(slot / BLK);
    coff  = OFF_W'(slot % BLK);
  end
endmodule

// File: rtl/npsf_walk_ctr.sv
module npsf_walk_ctr #(
  parameter int NBR   = 3,
  parameter int NBC   = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] bi,
  output logic [IDX_W-1:0] bj,
  output logic [2:0]       ph,
  output logic             last
);
  logic ph_wrap, bj_wrap;

  assign ph_wrap = (ph == 3'd4);
  assign bj_wrap = (bj == IDX_W'(NBC - 1));
  assign last    = ph_wrap && bj_wrap && (bi == IDX_W'(NBR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bi <= '0;
      bj <= '0;
      ph <= 3'd0;
    end else if (clr) begin
      bi <= '0;
      bj <= '0;
      ph <= 3'd0;
    end else if (step && !last) begin
      if (!ph_wrap) begin
        ph <= ph + 3'd1;
      end else begin
        ph <= 3'd0;
        if (!bj_wrap) begin
          bj <= bj + IDX_W'(1);
        end else begin
          bj <= '0;
          bi <= bi + IDX_W'(1);
        end
      end
    end
  end

  // Phase never leaves the five-step neighborhood walk.
  // R3
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= 3'd4);
endmodule

// File: rtl/npsf_cell_map.sv
module npsf_cell_map #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int BLK   = 3,
  parameter int OFF_W = 2,
  parameter int IDX_W = 2,
  parameter int RW    = 3,
  parameter int CW    = 3
) (
  input  logic [OFF_W-1:0] roff,
  input  logic [OFF_W-1:0] coff,
  input  logic [IDX_W-1:0] bi,
  input  logic [IDX_W-1:0] bj,
  input  logic [2:0]       ph,
  output logic [RW-1:0]    row,
  output logic [CW-1:0]    col,
  output logic             ok,
  output logic             base_ph
);
  import npsf_pkg::*;

  int br, bc, nr, nc;

  always_comb begin
    br      = int'(roff) + BLK * int'(bi);
    bc      = int'(coff) + BLK * int'(bj);
    nr      = br + ph_drow(ph);
    nc      = bc + ph_dcol(ph);
    ok      = (br < ROWS) && (bc < COLS) &&
              (nr >= 0) && (nr < ROWS) && (nc >= 0) && (nc < COLS);
    row     = RW'(nr);
    col     = CW'(nc);
    base_ph = (ph == PH_BASE);
  end
endmodule

// File: rtl/npsf_addr_gen.sv
module npsf_addr_gen #(
  parameter  int ROWS   = 8,
  parameter  int COLS   = 8,
  parameter  int BLK    = 3,
  localparam int RW     = $clog2(ROWS),
  localparam int CW     = $clog2(COLS),
  localparam int CASE_W = $clog2(BLK * BLK + 1),
  localparam int OFF_W  = $clog2(BLK + 1),
  localparam int NBR    = (ROWS + BLK - 1) / BLK,
  localparam int NBC    = (COLS + BLK - 1) / BLK,
  localparam int IDX_W  = $clog2((NBR > NBC ? NBR : NBC) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CASE_W-1:0] case_idx,
  input  logic              advance,
  output logic [RW+CW-1:0]  addr,
  output logic              addr_vld,
  output logic              is_base,
  output logic              done
);
  logic             dec_legal;
  logic [OFF_W-1:0] dec_roff, dec_coff;
  logic [OFF_W-1:0] roff_q, coff_q;
  logic             busy_q, done_q;
  logic [IDX_W-1:0] bi, bj;
  logic [2:0]       ph;
  logic             walk_last, cell_ok, base_ph;
  logic [RW-1:0]    cell_row;
  logic [CW-1:0]    cell_col;

  // Named events for the assertions.
  logic ev_start_ok, ev_start_bad, ev_step, ev_finish;

  npsf_case_dec #(.BLK(BLK), .CASE_W(CASE_W), .OFF_W(OFF_W)) u_dec (
    .k(case_idx), .legal(dec_legal), .roff(dec_roff), .coff(dec_coff)
  );

  assign ev_start_ok  = start && dec_legal;
  assign ev_start_bad = start && !dec_legal;
  assign ev_step      = busy_q && !start && (!cell_ok || advance);
  assign ev_finish    = ev_step && walk_last;

  npsf_walk_ctr #(.NBR(NBR), .NBC(NBC), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(start), .step(ev_step),
    .bi(bi), .bj(bj), .ph(ph), .last(walk_last)
  );

  npsf_cell_map #(
    .ROWS(ROWS), .COLS(COLS), .BLK(BLK), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .RW(RW), .CW(CW)
  ) u_map (
    .roff(roff_q), .coff(coff_q), .bi(bi), .bj(bj), .ph(ph),
    .row(cell_row), .col(cell_col), .ok(cell_ok), .base_ph(base_ph)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      roff_q <= '0;
      coff_q <= '0;
    end else if (start) begin
      busy_q <= dec_legal;
      done_q <= !dec_legal;
      roff_q <= dec_roff;
      coff_q <= dec_coff;
    end else if (ev_finish) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign addr     = {cell_row, cell_col};
  assign addr_vld = busy_q && cell_ok;
  assign is_base  = addr_vld && base_ph;
  assign done     = done_q;

  // R6
  in_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> (int'(addr[RW+CW-1:CW]) < ROWS) && (int'(addr[CW-1:0]) < COLS));

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && addr_vld));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !advance && !start) |=> (addr_vld && $stable(addr) && $stable(is_base)));

  // R9
  bad_case_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_bad |=> (done && !addr_vld));

  // R11
  first_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_ok |=> (addr_vld && is_base && !done));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/tb_npsf_addr_gen.sv
module tb_npsf_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] case_idx = 4'd0;
  logic       advance = 1'b0;
  logic [5:0] addr;
  logic       addr_vld, is_base, done;

  int n_chk = 0;
  int n_fail = 0;
  int exp_addr [0:63];
  bit exp_base [0:63];
  int exp_n;

  always #4 clk = ~clk;

  npsf_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .case_idx(case_idx),
    .advance(advance), .addr(addr), .addr_vld(addr_vld),
    .is_base(is_base), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Expected list: walk rows then columns from the offset in strides of 3.
  task automatic build_list(input int k);
    int r0, c0;
    exp_n = 0;
    r0 = (k - 1) / 3;
    c0 = (k - 1) % 3;
    for (int r = r0; r < 8; r += 3) begin
      for (int c = c0; c < 8; c += 3) begin
        exp_addr[exp_n] = r * 8 + c; exp_base[exp_n] = 1; exp_n++;
        if (r > 0) begin exp_addr[exp_n] = (r - 1) * 8 + c; exp_base[exp_n] = 0; exp_n++; end
        if (r < 7) begin exp_addr[exp_n] = (r + 1) * 8 + c; exp_base[exp_n] = 0; exp_n++; end
        if (c > 0) begin exp_addr[exp_n] = r * 8 + c - 1; exp_base[exp_n] = 0; exp_n++; end
        if (c < 7) begin exp_addr[exp_n] = r * 8 + c + 1; exp_base[exp_n] = 0; exp_n++; end
      end
    end
  endtask

  task automatic pulse_start(input int k);
    @(negedge clk);
    start = 1'b1;
    case_idx = 4'(k);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Collect every address of case k, compare in order; optionally stall on item 0.
  task automatic run_case(input int k, input bit stall);
    int got;
    int guard;
    build_list(k);
    pulse_start(k);
    // R11: first base cell presented right after start
    chk(addr_vld && is_base, "R11 first base", int'(addr_vld), 1);
    got = 0;
    guard = 0;
    while (!done && guard < 400) begin
      guard++;
      if (addr_vld) begin
        if (got < exp_n) begin
          chk(int'(addr) == exp_addr[got], $sformatf("R2/R3/R4/R6 case %0d item %0d addr", k, got),
              int'(addr), exp_addr[got]);
          chk(is_base == exp_base[got], $sformatf("R5 case %0d item %0d role", k, got),
              int'(is_base), int'(exp_base[got]));
        end else begin
          chk(1'b0, $sformatf("R6 case %0d extra addr", k), int'(addr), -1);
        end
        if (stall && got == 0) begin
          for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            // R7: held while no advance
            chk(addr_vld && int'(addr) == exp_addr[0] && is_base,
                "R7 hold", int'(addr), exp_addr[0]);
          end
        end
        got++;
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(got == exp_n, $sformatf("R6 case %0d count", k), got, exp_n);
    // R8: done high, no address, and it stays
    chk(done && !addr_vld, "R8 done", int'(done), 1);
    repeat (4) @(negedge clk);
    chk(done && !addr_vld, "R8 done sticky", int'(done), 1);
  endtask

  task automatic t_reset;
    // R1
    chk(!addr_vld && !done, "R1 reset state", int'({addr_vld, done}), 0);
  endtask

  task automatic t_bad_case(input int k);
    pulse_start(k);
    // R9
    chk(done && !addr_vld, $sformatf("R9 case %0d rejected", k), int'({done, addr_vld}), 2);
    repeat (3) begin
      @(negedge clk);
      chk(done && !addr_vld, "R9 no output", int'({done, addr_vld}), 2);
    end
  endtask

  task automatic t_restart;
    pulse_start(1);
    repeat (3) begin
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
      @(negedge clk);
    end
    pulse_start(9);
    // R10: new case begins at its first base (row 2, col 2 -> 18)
    chk(addr_vld && is_base && addr == 6'd18 && !done, "R10 restart", int'(addr), 18);
    run_case(9, 1'b0);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case(1, 1'b1);
    run_case(2, 1'b0);
    run_case(9, 1'b1);
    for (int k = 3; k <= 8; k++) run_case(k, 1'b0);
    t_bad_case(0);
    t_bad_case(10);
    t_bad_case(15);
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule